// File: doc/BRIEF.md
# DRAM Byte-Lane Write Strobe Sequencer

This block drives the write side of a 16-bit DRAM that has one active-low write strobe for the upper byte and one for the lower byte. It takes a single-cycle write request with two byte enables and a timing choice. In the early timing, the strobes fall before the column strobe. In the late timing, a read phase comes first and the strobes fall after the column strobe. The block then sequences the active-low strobes, the active-low output-enable line and the enable for the controller's own data-bus drivers. The column strobe comes from an external row/column timing generator and is only observed here.

The ordering rules are fixed in logic. Both byte strobes move on the same clock, so the data is never latched by a staggered strobe. A byte that is not enabled keeps its strobe high. The controller starts driving data only after the memory's output buffer has been turned off for at least one clock, and it stops driving only after both strobes are back high. A request with no byte enabled is refused with an error pulse.

Top module: `dram_wstrobe_ctl`

## Requirements
- R1: After reset both strobes and `oe_n` are high, `dq_drive` is low, `req_ready` is high, and `req_err` and `done` are low.
- R2: When both byte enables are set (`req_be` = 2'b11), `we_hi_n` and `we_lo_n` fall on the same clock and rise on the same clock.
- R3: A strobe whose byte enable is 0 (bit 1 = upper, bit 0 = lower) stays high for the whole cycle.
- R4: With `req_late` = 0 (early timing), the enabled strobes are low before `cas_n` is first seen low, and `oe_n` stays high for the whole cycle.
- R5: With `req_late` = 1 (late timing), `oe_n` is low for exactly RD_CYC clocks, starting one clock after `cas_n` is seen low. The strobes fall only after `oe_n` has returned high.
- R6: `dq_drive` is never high while `oe_n` is low, and it rises only when `oe_n` was already high on the previous clock.
- R7: `dq_drive` falls only after both strobes have been high for at least one clock.
- R8: While `cas_n` is low, the strobes stay low for exactly WP_CYC clocks.
- R9: A request accepted with `req_be` = 2'b00 gives a one-clock `req_err` pulse on the next clock. It produces no strobe, no output-enable and no drive activity, and `req_ready` stays high.
- R10: While `req_ready` is low, `req_valid` is ignored. It raises no error and does not change which strobes fire.
- R11: After the strobes are released and drive is off, `cas_n` going high ends the cycle with a one-clock `done` pulse, and `req_ready` rises on that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request, sampled when `req_ready` is high |
| req_be | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| req_late | input | 1 | 0 = early timing, 1 = late timing with read phase |
| cas_n | input | 1 | Column strobe from the external timing generator |
| req_ready | output | 1 | High when idle and able to accept a request |
| req_err | output | 1 | One-clock pulse for a request with no byte enabled |
| done | output | 1 | One-clock pulse at the end of a write cycle |
| we_hi_n | output | 1 | Upper-byte write strobe, active low |
| we_lo_n | output | 1 | Lower-byte write strobe, active low |
| oe_n | output | 1 | Memory output enable, active low |
| dq_drive | output | 1 | Enables the controller's write-data drivers |

## Verification
Two things can coincide at the edges of a late-timing cycle: the hand-off from output enable to data drive, and the release of the strobes against the drop of drive. The bench reaches both with every late-timing request. It varies the distance between the request and `cas_n`, and it sends stray requests while the block is busy. For each clock it records when `oe_n`, the strobes and `dq_drive` change, and it judges the edges by their order in clocks, never by their absolute time.

// File: rtl/dwsc_pkg.sv
package dwsc_pkg;
    localparam int LANES = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_E_WAIT,
        S_L_WAIT,
        S_L_READ,
        S_L_OEOFF,
        S_L_SETUP,
        S_PULSE,
        S_DRV_OFF,
        S_CAS_HI
    } seq_state_e;
endpackage

// File: rtl/dwsc_strobe_lane.sv
module dwsc_strobe_lane (
    input  logic fire,
    input  logic lane_en,
    output logic strobe_n
);
    always_comb strobe_n = ~(fire & lane_en);
endmodule

// File: rtl/dram_wstrobe_ctl.sv
module dram_wstrobe_ctl #(
    parameter int WP_CYC = 3,
    parameter int RD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_be,
    input  logic       req_late,
    input  logic       cas_n,
    output logic       req_ready,
    output logic       req_err,
    output logic       done,
    output logic       we_hi_n,
    output logic       we_lo_n,
    output logic       oe_n,
    output logic       dq_drive
);
    import dwsc_pkg::*;

    localparam int MAXC  = (WP_CYC > RD_CYC) ? WP_CYC : RD_CYC;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [LANES-1:0] be;
        logic             we_act;
        logic             oe_act;
        logic             drv;
        logic             err;
        logic             fin;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        s_d.fin = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_be == '0) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.be = req_be;
                        if (req_late) begin
                            s_d.st = S_L_WAIT;
                        end else begin
                            s_d.st     = S_E_WAIT;
                            s_d.we_act = 1'b1;
                            s_d.drv    = 1'b1;
                        end
                    end
                end
            end
            S_E_WAIT: begin
                if (!cas_n) begin
                    s_d.st  = S_PULSE;
                    s_d.cnt = CNT_W'(WP_CYC - 1);
                end
            end
            S_L_WAIT: begin
                if (!cas_n) begin
                    s_d.st     = S_L_READ;
                    s_d.oe_act = 1'b1;
                    s_d.cnt    = CNT_W'(RD_CYC - 1);
                end
            end
            S_L_READ: begin
                if (s_q.cnt == '0) begin
                    s_d.st     = S_L_OEOFF;
                    s_d.oe_act = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            S_L_OEOFF: begin
                s_d.st  = S_L_SETUP;
                s_d.drv = 1'b1;
            end
            S_L_SETUP: begin
                s_d.st     = S_PULSE;
                s_d.we_act = 1'b1;
                s_d.cnt    = CNT_W'(WP_CYC - 1);
            end
            S_PULSE: begin
                if (s_q.cnt == '0) begin
                    s_d.st     = S_DRV_OFF;
                    s_d.we_act = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            S_DRV_OFF: begin
                s_d.st  = S_CAS_HI;
                s_d.drv = 1'b0;
            end
            S_CAS_HI: begin
                if (cas_n) begin
                    s_d.st  = S_IDLE;
                    s_d.fin = 1'b1;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, cnt: '0, be: '0, we_act: 1'b0,
                     oe_act: 1'b0, drv: 1'b0, err: 1'b0, fin: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    logic [LANES-1:0] lane_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dwsc_strobe_lane u_lane (
            .fire     (s_q.we_act),
            .lane_en  (s_q.be[g]),
            .strobe_n (lane_n[g])
        );
    end

    assign we_hi_n   = lane_n[1];
    assign we_lo_n   = lane_n[0];
    assign oe_n      = ~s_q.oe_act;
    assign dq_drive  = s_q.drv;
    assign req_ready = (s_q.st == S_IDLE);
    assign req_err   = s_q.err;
    assign done      = s_q.fin;
endmodule

// File: rtl/dwsc_checker.sv
module dwsc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_be,
    input logic       req_ready,
    input logic       req_err,
    input logic       we_hi_n,
    input logic       we_lo_n,
    input logic       oe_n,
    input logic       dq_drive
);
    a_r2_fall_together: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_hi_n && !we_lo_n) |-> ($fell(we_hi_n) == $fell(we_lo_n)));

    a_r2_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_hi_n) && !$past(we_lo_n)) |-> $rose(we_lo_n));

    a_r5_no_strobe_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_hi_n && we_lo_n));

    a_r6_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_drive && !oe_n));

    a_r6_oe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_drive) |-> $past(oe_n));

    a_r7_drive_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_drive) |-> ($past(we_hi_n) && $past(we_lo_n)));

    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(req_valid && req_ready && (req_be == 2'b00)));
endmodule

bind dram_wstrobe_ctl dwsc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_be    (req_be),
    .req_ready (req_ready),
    .req_err   (req_err),
    .we_hi_n   (we_hi_n),
    .we_lo_n   (we_lo_n),
    .oe_n      (oe_n),
    .dq_drive  (dq_drive)
);

// File: tb/dram_wstrobe_ctl_tb.sv
`timescale 1ns/1ps
module dram_wstrobe_ctl_tb;
    localparam int WP = 3;
    localparam int RD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_be = 2'b00;
    logic req_late = 1'b0;
    logic cas_n = 1'b1;
    logic req_ready, req_err, done, we_hi_n, we_lo_n, oe_n, dq_drive;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dram_wstrobe_ctl #(.WP_CYC(WP), .RD_CYC(RD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_be(req_be),
        .req_late(req_late), .cas_n(cas_n), .req_ready(req_ready),
        .req_err(req_err), .done(done), .we_hi_n(we_hi_n), .we_lo_n(we_lo_n),
        .oe_n(oe_n), .dq_drive(dq_drive)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int first_of(input int a, input int b);
        if (a < 0) return b;
        if (b < 0) return a;
        return (a < b) ? a : b;
    endfunction

    task automatic run_err();
        @(negedge clk);
        req_valid = 1'b1; req_be = 2'b00; req_late = 1'($urandom_range(0, 1));
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_err == 1'b1, "R9 err pulse", int'(req_err), 1);
        chk(we_hi_n && we_lo_n && oe_n && !dq_drive && req_ready,
            "R9 no activity", int'({we_hi_n, we_lo_n, oe_n, dq_drive, req_ready}), 5'b11101);
        @(negedge clk);
        chk(req_err == 1'b0, "R9 err one clock", int'(req_err), 0);
    endtask

    task automatic run_txn(input logic [1:0] be, input logic late, input int d, input int spur);
        int hi_f = -1, lo_f = -1, hi_l = -1, lo_l = -1;
        int oe_cnt = 0, oe_l = -10, drv_f = -1, drv_l = -1;
        int cas_t = -1, wc_cnt = 0, done_cnt = 0;
        bit drv_oe_bad = 0, busy_bad = 0, saw_we = 0;
        int we_f, we_l;
        @(negedge clk);
        req_valid = 1'b1; req_be = be; req_late = late;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 1; t < 200; t++) begin
            if (!we_hi_n) begin if (hi_f < 0) hi_f = t; hi_l = t; saw_we = 1; end
            if (!we_lo_n) begin if (lo_f < 0) lo_f = t; lo_l = t; saw_we = 1; end
            if (!oe_n) begin oe_cnt++; oe_l = t; end
            if (dq_drive) begin
                if (drv_f < 0) drv_f = t;
                drv_l = t;
                if (!oe_n) drv_oe_bad = 1;
            end
            if ((!we_hi_n || !we_lo_n) && !cas_n) wc_cnt++;
            if (req_err) busy_bad = 1;
            if (done) done_cnt++;
            if (done && req_ready) break;
            if (req_ready && !done) busy_bad = 1;
            req_valid = 1'b0;
            if (t == spur) begin req_valid = 1'b1; req_be = ~be; req_late = ~late; end
            if (t == 1 + d) begin cas_n = 1'b0; cas_t = t + 1; end
            if (saw_we && we_hi_n && we_lo_n && !dq_drive && !cas_n) cas_n = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        we_f = first_of(hi_f, lo_f);
        we_l = imax(hi_l, lo_l);
        if (be == 2'b11) begin
            chk(hi_f == lo_f, "R2 fall same clock", hi_f, lo_f);
            chk(hi_l == lo_l, "R2 rise same clock", hi_l, lo_l);
        end
        if (!be[1]) chk(hi_f < 0, "R3 upper stays high", hi_f, -1);
        if (!be[0]) chk(lo_f < 0, "R3 lower stays high", lo_f, -1);
        if (!late) begin
            chk(we_f >= 1 && we_f < cas_t, "R4 strobe before cas", we_f, cas_t - 1);
            chk(oe_cnt == 0, "R4 oe stays high", oe_cnt, 0);
        end else begin
            chk(oe_cnt == RD, "R5 oe low length", oe_cnt, RD);
            chk(we_f > oe_l && we_f > cas_t, "R5 strobe after oe off", we_f, oe_l + 1);
        end
        chk(!drv_oe_bad && drv_f > oe_l + 1, "R6 drive after oe gap", drv_f, oe_l + 2);
        chk(drv_l > we_l && drv_f <= we_f, "R7 drive spans strobes", drv_l, we_l + 1);
        chk(wc_cnt == WP, "R8 strobe width under cas", wc_cnt, WP);
        chk(!busy_bad, "R10 busy requests ignored", int'(busy_bad), 0);
        chk(done_cnt == 1 && req_ready, "R11 done pulse", done_cnt, 1);
        @(negedge clk);
        chk(!done, "R11 done one clock", int'(done), 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(we_hi_n && we_lo_n && oe_n && !dq_drive, "R1 reset outputs",
            int'({we_hi_n, we_lo_n, oe_n, dq_drive}), 4'b1110);
        chk(req_ready && !req_err && !done, "R1 reset handshake",
            int'({req_ready, req_err, done}), 3'b100);
        run_txn(2'b11, 1'b0, 0, 0);
        run_txn(2'b11, 1'b1, 0, 0);
        run_txn(2'b01, 1'b0, 2, 1);
        run_txn(2'b10, 1'b1, 1, 2);
        run_txn(2'b11, 1'b1, 3, 3);
        run_err();
        for (int i = 0; i < 40; i++) begin
            logic [1:0] be = 2'($urandom_range(0, 3));
            if (be == 2'b00) run_err();
            else run_txn(be, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                         int'($urandom_range(0, 3)));
        end
        report();
    end
endmodule